// File: doc/BRIEF.md
# Inverted Page Table Lookup Engine

This engine turns a virtual page number, tagged with a process identifier, into a physical address. It searches an inverted page table held in an attached memory. That table has one entry per physical frame, so its size follows the amount of physical memory and not the size of the virtual address space. A frame number is never stored in the table. The index of the entry that matches *is* the frame number.

For each request the engine hashes the page number and process ID to a home slot. It then reads a short run of consecutive slots, starting at the home slot, at the table base address plus the slot index. At each slot it compares the stored page number and process ID with the request. It stops at the first entry that matches, or at the first entry that is not valid. If every allowed slot misses, it reports a page fault.

A request is offered with `req_valid`, and the engine takes it in any cycle in which `req_ready` is high. `req_ready` is high only while the engine is idle, so back-pressure lasts for the whole walk. An offer made while busy is held off and has no effect on the walk in progress. The result comes back as a single-cycle `done` pulse and cannot be stalled. The table memory answers a read one cycle after `mem_rd_en`.

Top module: `ipt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_rd_en` is 0.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the result is returned. A request offered while busy changes neither the result nor the read sequence.
- R3: The first read of a walk is at address `tbl_base + h`, where `h = vpn[9:0] XOR {2'b00, pid}`.
- R4: Each later read of the same walk is at the next slot. Slot arithmetic wraps modulo 1024, so slot 1023 is followed by slot 0. The address is always `tbl_base` plus the slot.
- R5: An entry hits only if its valid bit is 1, its stored VPN equals the request VPN and its stored PID equals the request PID. On a hit, `resp_paddr = {slot[9:0], offset[11:0]}` and `resp_fault` is 0.
- R6: The walk stops at the first hit. `resp_reads` equals the number of reads issued, from 1 to 4.
- R7: Reading an entry whose valid bit is 0 ends the walk at once. The engine reports a fault, with `resp_paddr` equal to 0 and `resp_reads` equal to the reads so far.
- R8: If four valid entries are read and none matches, the engine reports a fault with `resp_reads` equal to 4.
- R9: `done` is high for exactly one cycle per accepted request.
- R10: There is at most one outstanding read: `mem_rd_en` is never high in two cycles in a row, and no walk issues more than 4 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 16 | Table base address, in entry units |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle; the request is taken on this edge |
| req_vpn | input | 20 | Virtual page number |
| req_pid | input | 8 | Process identifier |
| req_offset | input | 12 | Page offset, passed through untranslated |
| mem_rd_en | output | 1 | Read strobe to the table memory |
| mem_addr | output | 16 | Entry address being read |
| mem_rd_valid | input | 1 | Valid bit of the entry read, one cycle after the strobe |
| mem_rd_vpn | input | 20 | Stored VPN of the entry read |
| mem_rd_pid | input | 8 | Stored PID of the entry read |
| done | output | 1 | One-cycle completion pulse |
| resp_fault | output | 1 | Page fault; valid while `done` is high |
| resp_paddr | output | 22 | Physical address; valid while `done` is high |
| resp_reads | output | 3 | Number of table reads used; valid while `done` is high |

## Verification
A wrong slot register or a broken increment shows up on `mem_addr` in the very next read strobe. It is also corrupted in the frame field of `resp_paddr`, because the frame is the slot. A probe counter that is off by one shows up in `resp_reads`, or as a walk that stops too early or runs to a fifth read, when `done` rises, at most eight cycles after acceptance. A control state that is stuck shows up as `req_ready` failing to return, a `done` pulse longer than one cycle, or two reads in back-to-back cycles.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_READ = 2'd1,
    WALK_CMP  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int IDX_W = 10
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [PID_W-1:0] pid,
  output logic [IDX_W-1:0] home_slot
);
  always_comb home_slot = vpn[IDX_W-1:0] ^ IDX_W'(pid);
endmodule

// File: rtl/ipt_match.sv
module ipt_match #(
  parameter int VPN_W = 20,
  parameter int PID_W = 8
) (
  input  logic             ent_valid,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic [PID_W-1:0] ent_pid,
  input  logic [VPN_W-1:0] want_vpn,
  input  logic [PID_W-1:0] want_pid,
  output logic             hit,
  output logic             empty
);
  always_comb begin
    empty = !ent_valid;
    hit   = ent_valid && (ent_vpn == want_vpn) && (ent_pid == want_pid);
  end
endmodule

// File: rtl/ipt_ctrl.sv
module ipt_ctrl
  import ipt_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int AW     = 16,
  parameter int PROBES = 4,
  localparam int CW    = $clog2(PROBES + 1),
  localparam int PA_W  = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    tbl_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PID_W-1:0] req_pid,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [IDX_W-1:0] home_slot,
  input  logic             hit,
  input  logic             empty,
  output logic [VPN_W-1:0] cur_vpn,
  output logic [PID_W-1:0] cur_pid,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  output logic             done,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [CW-1:0]    resp_reads
);
  walk_st_e         st;
  logic [IDX_W-1:0] slot;
  logic [CW-1:0]    cnt;
  logic [OFF_W-1:0] cur_off;

  always_comb begin
    req_ready = (st == WALK_IDLE);
    mem_rd_en = (st == WALK_READ);
    mem_addr  = tbl_base + AW'(slot);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= WALK_IDLE;
      slot       <= '0;
      cnt        <= '0;
      cur_vpn    <= '0;
      cur_pid    <= '0;
      cur_off    <= '0;
      done       <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
      resp_reads <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        WALK_IDLE: begin
          if (req_valid) begin
            cur_vpn <= req_vpn;
            cur_pid <= req_pid;
            cur_off <= req_offset;
            slot    <= home_slot;
            cnt     <= '0;
            st      <= WALK_READ;
          end
        end
        WALK_READ: begin
          cnt <= cnt + 1'b1;
          st  <= WALK_CMP;
        end
        WALK_CMP: begin
          if (hit) begin
            done       <= 1'b1;
            resp_fault <= 1'b0;
            resp_paddr <= {slot, cur_off};
            resp_reads <= cnt;
            st         <= WALK_IDLE;
          end else if (empty || cnt == CW'(PROBES)) begin
            done       <= 1'b1;
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            resp_reads <= cnt;
            st         <= WALK_IDLE;
          end else begin
            slot <= slot + 1'b1;
            st   <= WALK_READ;
          end
        end
        default: st <= WALK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int AW     = 16,
  parameter int PROBES = 4,
  localparam int CW    = $clog2(PROBES + 1),
  localparam int PA_W  = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    tbl_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PID_W-1:0] req_pid,
  input  logic [OFF_W-1:0] req_offset,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rd_valid,
  input  logic [VPN_W-1:0] mem_rd_vpn,
  input  logic [PID_W-1:0] mem_rd_pid,
  output logic             done,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [CW-1:0]    resp_reads
);
  logic [IDX_W-1:0] home_slot;
  logic [VPN_W-1:0] cur_vpn;
  logic [PID_W-1:0] cur_pid;
  logic             hit, empty;

  ipt_hash #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_hash (
    .vpn(req_vpn), .pid(req_pid), .home_slot(home_slot)
  );

  ipt_match #(.VPN_W(VPN_W), .PID_W(PID_W)) u_match (
    .ent_valid(mem_rd_valid), .ent_vpn(mem_rd_vpn), .ent_pid(mem_rd_pid),
    .want_vpn(cur_vpn), .want_pid(cur_pid), .hit(hit), .empty(empty)
  );

  ipt_ctrl #(
    .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .AW(AW), .PROBES(PROBES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_pid(req_pid), .req_offset(req_offset),
    .home_slot(home_slot), .hit(hit), .empty(empty),
    .cur_vpn(cur_vpn), .cur_pid(cur_pid),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .done(done), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .resp_reads(resp_reads)
  );
endmodule

// File: rtl/ipt_walker_chk.sv
module ipt_walker_chk #(
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int AW     = 16,
  parameter int PROBES = 4,
  localparam int CW    = $clog2(PROBES + 1),
  localparam int PA_W  = IDX_W + OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    tbl_base,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VPN_W-1:0] req_vpn,
  input logic [PID_W-1:0] req_pid,
  input logic [OFF_W-1:0] req_offset,
  input logic             mem_rd_en,
  input logic [AW-1:0]    mem_addr,
  input logic             done,
  input logic             resp_fault,
  input logic [PA_W-1:0]  resp_paddr,
  input logic [CW-1:0]    resp_reads
);
  logic [CW-1:0]    c_cnt;
  logic [IDX_W-1:0] c_last, c_home, rd_slot;
  logic [OFF_W-1:0] c_off;
  logic [AW-1:0]    rd_delta;

  always_comb begin
    rd_delta = mem_addr - tbl_base;
    rd_slot  = rd_delta[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_cnt <= '0; c_last <= '0; c_home <= '0; c_off <= '0;
    end else if (req_valid && req_ready) begin
      c_cnt  <= '0;
      c_home <= req_vpn[IDX_W-1:0] ^ IDX_W'(req_pid);
      c_off  <= req_offset;
    end else if (mem_rd_en) begin
      c_cnt  <= c_cnt + 1'b1;
      c_last <= rd_slot;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> req_ready && !done && !mem_rd_en) // R1
    else $error("AST_RESET_IDLE");
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |-> !req_ready) // R2
    else $error("AST_BUSY_NO_READY");
  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd_en && c_cnt == '0) |-> rd_slot == c_home) // R3
    else $error("AST_FIRST_SLOT");
  AST_NEXT_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd_en && c_cnt != '0) |-> rd_slot == IDX_W'(c_last + 1'b1)) // R4
    else $error("AST_NEXT_SLOT");
  AST_HIT_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (done && !resp_fault) |-> resp_paddr == {c_last, c_off}) // R5
    else $error("AST_HIT_FRAME");
  AST_READ_COUNT: assert property (@(posedge clk) disable iff (!rst_n) done |-> resp_reads == c_cnt && resp_reads != '0) // R6
    else $error("AST_READ_COUNT");
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) // R9
    else $error("AST_DONE_PULSE");
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |=> !mem_rd_en) // R10
    else $error("AST_ONE_OUTSTANDING");
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |-> c_cnt < CW'(PROBES)) // R10
    else $error("AST_READ_LIMIT");
endmodule

bind ipt_walker ipt_walker_chk #(
  .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
  .AW(AW), .PROBES(PROBES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_vpn(req_vpn), .req_pid(req_pid), .req_offset(req_offset),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .done(done),
  .resp_fault(resp_fault), .resp_paddr(resp_paddr), .resp_reads(resp_reads)
);

// File: tb/ipt_walker_test.sv
`timescale 1ns/1ps
module ipt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tbl_base = 16'h1200;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic [7:0]  req_pid = '0;
  logic [11:0] req_offset = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic        mem_rd_valid;
  logic [19:0] mem_rd_vpn;
  logic [7:0]  mem_rd_pid;
  logic        done, resp_fault;
  logic [21:0] resp_paddr;
  logic [2:0]  resp_reads;

  always #4 clk = ~clk;

  ipt_walker uut (.*);

  logic        t_v   [1024];
  logic [19:0] t_vpn [1024];
  logic [7:0]  t_pid [1024];
  logic [15:0] rec_addr [8];
  int          rec_n = 0;
  int          tests = 0, fails = 0;
  int unsigned seed = 32'd7741;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_valid <= t_v[10'(mem_addr - tbl_base)];
      mem_rd_vpn   <= t_vpn[10'(mem_addr - tbl_base)];
      mem_rd_pid   <= t_pid[10'(mem_addr - tbl_base)];
      if (rec_n < 8) rec_addr[rec_n] <= mem_addr;
      rec_n <= rec_n + 1;
    end
  end

  function automatic logic [9:0] home(input logic [19:0] v, input logic [7:0] p);
    return v[9:0] ^ {2'b00, p};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [19:0] v, input logic [7:0] p,
                       output logic f, output logic [9:0] fr, output int n);
    logic [9:0] s = home(v, p);
    f = 1'b1; fr = '0; n = 0;
    for (int i = 0; i < 4; i++) begin
      n = i + 1;
      if (!t_v[s]) return;
      if (t_vpn[s] == v && t_pid[s] == p) begin f = 1'b0; fr = s; return; end
      s = s + 10'd1;
    end
  endtask

  task automatic run(input logic [19:0] v, input logic [7:0] p, input logic [11:0] o,
                     input bit poke);
    logic ef; logic [9:0] efr; int en; int w;
    model(v, p, ef, efr, en);
    rec_n = 0;
    @(negedge clk);
    req_vpn = v; req_pid = p; req_offset = o; req_valid = 1'b1;
    @(negedge clk);
    check("R2 ready low after accept", req_ready, 0);
    req_valid = 1'b0;
    if (poke) begin req_vpn = ~v; req_pid = ~p; end
    w = 0;
    while (!done && w < 40) begin
      req_valid = poke && !req_ready;
      @(negedge clk); w++;
    end
    req_valid = 1'b0;
    check("R9 done seen", done, 1);
    check("R2 ready on done", req_ready, 1);
    check(ef ? "R7/R8 fault" : "R5 fault clear", resp_fault, ef);
    check("R6 reads", resp_reads, en);
    check("R5 paddr", resp_paddr, ef ? 0 : {efr, o});
    check("R10 read count", rec_n, en);
    for (int i = 0; i < en && i < 8; i++)
      check(i == 0 ? "R3 first addr" : "R4 next addr", rec_addr[i],
            tbl_base + 16'(10'(home(v, p) + 10'(i))));
    @(negedge clk);
    check("R9 one-cycle done", done, 0);
    check("R2 no extra read", rec_n, en);
  endtask

  task automatic put(input int s, input logic v, input logic [19:0] vp, input logic [7:0] p);
    t_v[s] = v; t_vpn[s] = vp; t_pid[s] = p;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [9:0] h;
    for (int i = 0; i < 1024; i++) put(i, 1'b0, '0, '0);
    repeat (3) @(negedge clk);
    check("R1 ready", req_ready, 1);
    check("R1 done", done, 0);
    check("R1 no read", mem_rd_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", req_ready, 1);

    // R5 hit at first probe
    h = home(20'h12345, 8'h21);
    put(h, 1, 20'h12345, 8'h21);
    run(20'h12345, 8'h21, 12'hABC, 0);
    // R7 invalid at first probe
    run(20'h00777, 8'h05, 12'h001, 0);
    // R4 wrap: home 1022, hit at 4th probe (slot 1)
    put(1022, 1, 20'h003FF, 8'h02); put(1023, 1, 20'h55555, 8'h01);
    put(0, 1, 20'h00001, 8'h03);   put(1, 1, 20'hAB7FE, 8'h00);
    run(20'hAB7FE, 8'h00, 12'hFFF, 0);
    // R8 four valid misses
    run(20'hCD7FE, 8'h00, 12'h010, 0);
    // R5 VPN matches but PID differs; R7 invalid after mismatches
    h = home(20'h0F0F0, 8'h11);
    put(h, 1, 20'h0F0F0, 8'h12);
    run(20'h0F0F0, 8'h11, 12'h222, 0);
    // R2 request held during busy is ignored
    run(20'h12345, 8'h21, 12'h3C3, 1);

    for (int i = 0; i < 1024; i++)
      put(i, ($urandom(seed) % 8) != 0, 20'($urandom() % 16), 8'($urandom() % 4));
    for (int k = 0; k < 300; k++) begin
      int s = $urandom() % 1024;
      if (k % 2 == 0)
        run(t_vpn[s] ^ 20'($urandom() % 2), t_pid[s], 12'($urandom()), k % 5 == 0);
      else
        run(20'($urandom() % 32), 8'($urandom() % 4), 12'($urandom()), 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule